// File: doc/BRIEF.md
# Clock Holdover State Supervisor

This block supervises a local clock that normally follows an external timing reference. It watches a reference-valid flag and the measured phase error of the local clock, and reports one of five timing states: locked, holdover, degraded holdover, free-run and failed. While the reference is missing, it keeps an estimate of the accumulated time error. On every time tick it adds a programmed per-tick error increment, which is the fractional frequency error multiplied by the tick period. The estimate is graded against a warning threshold and a hard limit.

When the reference comes back, the block first requires it to stay valid for a programmed number of ticks. It then picks one of three actions. A restored reference whose phase offset is too large is rejected. A small offset is removed with a single phase step. Anything between those bands is slewed out, with a bounded correction on each tick, until the residual error falls inside a lock window. All state changes happen on clock edges where the tick input is high. The correction outputs are meant to feed the external servo that moves the local phase.

Top module: `holdover_supervisor`

## Requirements
- R1: After reset the status is free-run. The encoding on `state_o` is locked=0, holdover=1, degraded=2, free-run=3, failed=4. `state_o` changes only on a clock edge where `tick_i` is high.
- R2: When the reference is lost while locked, the next state is holdover if the clock has spent at least `min_lock_i` ticks locked (valid ticks counted after the lock tick). Otherwise the next state is free-run. The time-error estimate is 0 on entry.
- R3: Each tick spent in holdover, degraded or failed adds `ffe_i` to `time_err_o`, including the tick that moves the state on. Nothing is added in free-run or on a tick that starts while a slew is in progress.
- R4: From holdover or degraded, a tick whose updated estimate is strictly above `fail_thr_i` moves the state to failed. Otherwise, from holdover, an estimate strictly above `warn_thr_i` moves the state to degraded. An estimate equal to a threshold does not cross it.
- R5: `alarm_o` is high in every state except locked.
- R6: Outside locked, a decision on the restored reference is taken on the `qual_cnt_i`-th consecutive tick with `ref_valid_i` high. A tick with `ref_valid_i` low restarts the count.
- R7: If |`phase_err_i`| > `reject_thr_i` at the decision tick, `reject_o` pulses for one cycle, the state is kept and qualification starts again.
- R8: If |`phase_err_i`| <= `step_thr_i` at the decision tick, `step_o` and `adj_vld_o` pulse for one cycle with `adj_o` = -`phase_err_i`, and the state becomes locked.
- R9: Otherwise `slewing_o` rises. On that tick and on each later tick with |phase| > `lock_win_i`, `adj_vld_o` pulses with `adj_o` pointing toward zero and magnitude min(|phase|, `slew_max_i`). A tick with |phase| <= `lock_win_i` makes the state locked. A tick with `ref_valid_i` low ends the slew and the block keeps coasting.
- R10: `time_err_o` saturates at its all-ones value instead of wrapping, and is 0 after every transition into locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Periodic time tick, one cycle wide |
| ref_valid_i | input | 1 | External reference is usable |
| phase_err_i | input | PH_W | Signed measured phase error of the local clock |
| ffe_i | input | TE_W | Time-error increment per tick (frequency error times tick period) |
| warn_thr_i | input | TE_W | Degraded-holdover threshold on the estimate |
| fail_thr_i | input | TE_W | Time-error limit |
| min_lock_i | input | CNT_W | Locked ticks needed before loss for holdover |
| qual_cnt_i | input | CNT_W | Consecutive valid ticks before a restore decision |
| reject_thr_i | input | PH_W | Phase magnitude above which a reference is rejected |
| step_thr_i | input | PH_W | Phase magnitude up to which a step is used |
| slew_max_i | input | PH_W | Largest correction per tick while slewing |
| lock_win_i | input | PH_W | Residual phase accepted as locked |
| state_o | output | 3 | Timing status |
| alarm_o | output | 1 | High whenever not locked |
| slewing_o | output | 1 | Slew in progress |
| time_err_o | output | TE_W | Accumulated time-error estimate |
| step_o | output | 1 | One-cycle phase step pulse |
| reject_o | output | 1 | One-cycle reference reject pulse |
| adj_vld_o | output | 1 | Phase correction valid |
| adj_o | output | PH_W | Signed phase correction |

## Verification
The bench builds the block with TE_W=16, PH_W=16 and CNT_W=8. The 16-bit estimate can therefore be driven into saturation within a few ticks by raising the increment to 20000 in the middle of an outage. With an increment of 50 per tick, a 5000 limit and a 3500 warning level, a 60-tick outage stays in holdover. The estimate reaches degraded on tick 71, lands exactly on the limit at tick 100 without failing, and fails on tick 101. A step band of 100, a reject level of 1000 and a slew limit of 40 keep every restore path short: step, reject, positive and negative slews, and an aborted slew.

// File: rtl/holdover_pkg.sv
package holdover_pkg;

  typedef enum logic [2:0] {
    ST_LOCKED = 3'd0,
    ST_HOLD   = 3'd1,
    ST_DEGR   = 3'd2,
    ST_FREE   = 3'd3,
    ST_FAIL   = 3'd4
  } ho_state_e;

  typedef enum logic [1:0] {
    ACT_REJECT = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_SLEW   = 2'd2
  } ho_act_e;

endpackage

// File: rtl/ho_tick_counter.sv
module ho_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

  // R6
  cnt_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX);

endmodule

// File: rtl/ho_te_accum.sv
module ho_te_accum #(
  parameter int TE_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            add_i,
  input  logic [TE_W-1:0] inc_i,
  output logic [TE_W-1:0] te_o,
  output logic [TE_W-1:0] sum_o
);

  localparam logic [TE_W-1:0] TE_MAX = '1;

  logic [TE_W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, te_o} + {1'b0, inc_i};
    sum_o    = wide_sum[TE_W] ? TE_MAX : wide_sum[TE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     te_o <= '0;
    else if (clr_i)  te_o <= '0;
    else if (add_i)  te_o <= sum_o;
  end

  // R10
  te_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !clr_i) |=> te_o >= $past(te_o));

  // R10
  te_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> te_o == '0);

endmodule

// File: rtl/ho_restore_judge.sv
module ho_restore_judge
  import holdover_pkg::*;
#(
  parameter int PH_W = 24
) (
  input  logic signed [PH_W-1:0] phase_i,
  input  logic        [PH_W-1:0] reject_thr_i,
  input  logic        [PH_W-1:0] step_thr_i,
  input  logic        [PH_W-1:0] slew_max_i,
  input  logic        [PH_W-1:0] lock_win_i,
  output ho_act_e                act_o,
  output logic                   in_win_o,
  output logic signed [PH_W-1:0] corr_o
);

  localparam logic [PH_W-1:0] POS_MAX = {1'b0, {(PH_W-1){1'b1}}};

  logic [PH_W-1:0] mag;
  logic [PH_W-1:0] lim;

  always_comb begin
    mag = phase_i[PH_W-1] ? $unsigned(-phase_i) : $unsigned(phase_i);
    lim = (mag > slew_max_i) ? slew_max_i : mag;
    if (lim[PH_W-1]) lim = POS_MAX;
    corr_o   = phase_i[PH_W-1] ? $signed(lim) : -$signed(lim);
    in_win_o = (mag <= lock_win_i);
    if (mag > reject_thr_i)     act_o = ACT_REJECT;
    else if (mag <= step_thr_i) act_o = ACT_STEP;
    else                        act_o = ACT_SLEW;
  end

endmodule

// File: rtl/holdover_supervisor.sv
module holdover_supervisor
  import holdover_pkg::*;
#(
  parameter int TE_W  = 32,
  parameter int PH_W  = 24,
  parameter int CNT_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   ref_valid_i,
  input  logic signed [PH_W-1:0] phase_err_i,
  input  logic        [TE_W-1:0] ffe_i,
  input  logic        [TE_W-1:0] warn_thr_i,
  input  logic        [TE_W-1:0] fail_thr_i,
  input  logic       [CNT_W-1:0] min_lock_i,
  input  logic       [CNT_W-1:0] qual_cnt_i,
  input  logic        [PH_W-1:0] reject_thr_i,
  input  logic        [PH_W-1:0] step_thr_i,
  input  logic        [PH_W-1:0] slew_max_i,
  input  logic        [PH_W-1:0] lock_win_i,
  output logic             [2:0] state_o,
  output logic                   alarm_o,
  output logic                   slewing_o,
  output logic        [TE_W-1:0] time_err_o,
  output logic                   step_o,
  output logic                   reject_o,
  output logic                   adj_vld_o,
  output logic signed [PH_W-1:0] adj_o
);

  ho_state_e state_q, state_d;
  logic slewing_q, slewing_d;
  logic step_d, reject_d, adj_vld_d;
  logic signed [PH_W-1:0] adj_d;

  logic te_clr, te_add;
  logic lock_clr, lock_inc;
  logic qual_clr, qual_inc;
  logic [TE_W-1:0]  te_sum;
  logic [CNT_W-1:0] lock_cnt, qual_cnt;
  logic [CNT_W:0]   qual_next;
  logic             qual_done;

  ho_act_e                judge_act;
  logic                   judge_in_win;
  logic signed [PH_W-1:0] judge_corr;

  ho_te_accum #(.TE_W(TE_W)) u_te (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (te_clr),
    .add_i  (te_add),
    .inc_i  (ffe_i),
    .te_o   (time_err_o),
    .sum_o  (te_sum)
  );

  ho_tick_counter #(.W(CNT_W)) u_lock_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (lock_clr),
    .inc_i  (lock_inc),
    .cnt_o  (lock_cnt)
  );

  ho_tick_counter #(.W(CNT_W)) u_qual_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (qual_clr),
    .inc_i  (qual_inc),
    .cnt_o  (qual_cnt)
  );

  ho_restore_judge #(.PH_W(PH_W)) u_judge (
    .phase_i      (phase_err_i),
    .reject_thr_i (reject_thr_i),
    .step_thr_i   (step_thr_i),
    .slew_max_i   (slew_max_i),
    .lock_win_i   (lock_win_i),
    .act_o        (judge_act),
    .in_win_o     (judge_in_win),
    .corr_o       (judge_corr)
  );

  assign qual_next = {1'b0, qual_cnt} + 1'b1;
  assign qual_done = qual_next >= {1'b0, qual_cnt_i};

  always_comb begin
    state_d   = state_q;
    slewing_d = slewing_q;
    step_d    = 1'b0;
    reject_d  = 1'b0;
    adj_vld_d = 1'b0;
    adj_d     = '0;
    te_clr    = 1'b0;
    te_add    = 1'b0;
    lock_clr  = 1'b0;
    lock_inc  = 1'b0;
    qual_clr  = 1'b0;
    qual_inc  = 1'b0;

    if (tick_i) begin
      if (state_q == ST_LOCKED) begin
        if (ref_valid_i) begin
          lock_inc = 1'b1;
        end else begin
          state_d  = (lock_cnt >= min_lock_i) ? ST_HOLD : ST_FREE;
          te_clr   = 1'b1;
          qual_clr = 1'b1;
        end
      end else begin
        // coasting: estimate grows unless a slew is tracking the reference
        if (!slewing_q && state_q != ST_FREE) begin
          te_add = 1'b1;
          if (state_q == ST_HOLD || state_q == ST_DEGR) begin
            if (te_sum > fail_thr_i)                         state_d = ST_FAIL;
            else if (state_q == ST_HOLD && te_sum > warn_thr_i) state_d = ST_DEGR;
          end
        end

        if (slewing_q) begin
          if (!ref_valid_i) begin
            slewing_d = 1'b0;
            qual_clr  = 1'b1;
          end else if (judge_in_win) begin
            state_d   = ST_LOCKED;
            slewing_d = 1'b0;
            te_clr    = 1'b1;
            lock_clr  = 1'b1;
            qual_clr  = 1'b1;
          end else begin
            adj_vld_d = 1'b1;
            adj_d     = judge_corr;
          end
        end else if (ref_valid_i) begin
          if (qual_done) begin
            qual_clr = 1'b1;
            unique case (judge_act)
              ACT_REJECT: reject_d = 1'b1;
              ACT_STEP: begin
                step_d    = 1'b1;
                adj_vld_d = 1'b1;
                adj_d     = -phase_err_i;
                state_d   = ST_LOCKED;
                te_clr    = 1'b1;
                lock_clr  = 1'b1;
              end
              default: begin
                slewing_d = 1'b1;
                adj_vld_d = 1'b1;
                adj_d     = judge_corr;
              end
            endcase
          end else begin
            qual_inc = 1'b1;
          end
        end else begin
          qual_clr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FREE;
      slewing_q <= 1'b0;
      step_o    <= 1'b0;
      reject_o  <= 1'b0;
      adj_vld_o <= 1'b0;
      adj_o     <= '0;
    end else begin
      state_q   <= state_d;
      slewing_q <= slewing_d;
      step_o    <= step_d;
      reject_o  <= reject_d;
      adj_vld_o <= adj_vld_d;
      adj_o     <= adj_d;
    end
  end

  assign state_o   = state_q;
  assign alarm_o   = (state_q != ST_LOCKED);
  assign slewing_o = slewing_q;

  logic [PH_W-1:0] adj_mag;
  assign adj_mag = adj_o[PH_W-1] ? $unsigned(-adj_o) : $unsigned(adj_o);

  // R1
  state_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q inside {ST_LOCKED, ST_HOLD, ST_DEGR, ST_FREE, ST_FAIL});

  // R1
  state_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(state_q));

  // R4
  under_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !slewing_q && (state_q == ST_HOLD || state_q == ST_DEGR))
      |=> (state_q != ST_HOLD && state_q != ST_DEGR) || time_err_o <= $past(fail_thr_i));

  // R8
  step_locks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (state_o == ST_LOCKED && adj_vld_o));

  // R7
  reject_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (alarm_o && !adj_vld_o && !step_o));

  // R9
  slew_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_vld_o && slewing_o) |-> adj_mag <= $past(slew_max_i));

  // R10
  lock_clears_te_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOCKED && $past(state_q) != ST_LOCKED) |-> time_err_o == '0);

endmodule

// File: tb/sim_holdover_supervisor.sv
`timescale 1ns/1ps
module sim_holdover_supervisor;

  localparam int TE_W = 16;
  localparam int PH_W = 16;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                   rst_ni, tick_i, ref_valid_i;
  logic signed [PH_W-1:0] phase_err_i;
  logic        [TE_W-1:0] ffe_i, warn_thr_i, fail_thr_i;
  logic       [CNT_W-1:0] min_lock_i, qual_cnt_i;
  logic        [PH_W-1:0] reject_thr_i, step_thr_i, slew_max_i, lock_win_i;
  logic             [2:0] state_o;
  logic                   alarm_o, slewing_o, step_o, reject_o, adj_vld_o;
  logic        [TE_W-1:0] time_err_o;
  logic signed [PH_W-1:0] adj_o;

  holdover_supervisor #(.TE_W(TE_W), .PH_W(PH_W), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ref_valid_i(ref_valid_i),
    .phase_err_i(phase_err_i), .ffe_i(ffe_i), .warn_thr_i(warn_thr_i),
    .fail_thr_i(fail_thr_i), .min_lock_i(min_lock_i), .qual_cnt_i(qual_cnt_i),
    .reject_thr_i(reject_thr_i), .step_thr_i(step_thr_i), .slew_max_i(slew_max_i),
    .lock_win_i(lock_win_i), .state_o(state_o), .alarm_o(alarm_o),
    .slewing_o(slewing_o), .time_err_o(time_err_o), .step_o(step_o),
    .reject_o(reject_o), .adj_vld_o(adj_vld_o), .adj_o(adj_o)
  );

  localparam logic [2:0] S_L = 3'd0, S_H = 3'd1, S_D = 3'd2, S_F = 3'd3, S_X = 3'd4;
  // flag order: {slewing, adj_vld, reject, step}
  localparam logic [3:0] F_NONE = 4'b0000, F_STEP = 4'b0101, F_REJ = 4'b0010, F_SLEW = 4'b1100;

  typedef struct {
    logic [2:0]             st;
    logic [TE_W-1:0]        te;
    logic [3:0]             fl;
    logic signed [PH_W-1:0] adj;
    string                  tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic tick_seen = 1'b0;

  always @(posedge clk) tick_seen <= tick_i;

  task automatic chk(bit ok, string tag, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: one tick with its expected result
  task automatic tk(bit rv, int ph, logic [2:0] es, int ete, logic [3:0] efl, int eadj, string tag);
    exp_t e;
    ref_valid_i = rv;
    phase_err_i = PH_W'(ph);
    tick_i      = 1'b1;
    e.st = es; e.te = TE_W'(ete); e.fl = efl; e.adj = PH_W'(eadj); e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    tick_i = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (tick_seen) begin
      exp_t e;
      logic [3:0] fl;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL monitor: actual=result expected=none");
      end else begin
        e  = exp_q.pop_front();
        fl = {slewing_o, adj_vld_o, reject_o, step_o};
        if (state_o !== e.st || time_err_o !== e.te || fl !== e.fl ||
            alarm_o !== (e.st != S_L) || (e.fl[2] && adj_o !== e.adj)) begin
          n_bad++;
          $display("FAIL %s: actual st=%0d te=%0d fl=%b alarm=%b adj=%0d expected st=%0d te=%0d fl=%b alarm=%b adj=%0d",
                   e.tag, state_o, time_err_o, fl, alarm_o, adj_o,
                   e.st, e.te, e.fl, (e.st != S_L), e.adj);
        end
      end
    end
  end

  initial begin
    #750000;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    int ph;
    rst_ni = 1'b0; tick_i = 1'b0; ref_valid_i = 1'b0; phase_err_i = '0;
    ffe_i = 16'd50; warn_thr_i = 16'd3500; fail_thr_i = 16'd5000;
    min_lock_i = 8'd4; qual_cnt_i = 8'd3;
    reject_thr_i = 16'd1000; step_thr_i = 16'd100; slew_max_i = 16'd40; lock_win_i = 16'd10;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(state_o == S_F, "R1 reset state", state_o, S_F);
    chk(alarm_o == 1'b1, "R5 reset alarm", alarm_o, 1);
    chk(time_err_o == 0, "R1 reset estimate", time_err_o, 0);
    ref_valid_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(state_o == S_F, "R1 no change without tick", state_o, S_F);

    // qualify from free-run, then step
    tk(1, 50, S_F, 0, F_NONE, 0, "R6 qualifying 1");
    tk(1, 50, S_F, 0, F_NONE, 0, "R6 qualifying 2");
    tk(1, 50, S_L, 0, F_STEP, -50, "R8 step lock");
    tk(1, 0, S_L, 0, F_NONE, 0, "R5 locked");
    tk(1, 0, S_L, 0, F_NONE, 0, "R5 locked");
    tk(0, 0, S_F, 0, F_NONE, 0, "R2 short lock to free-run");
    tk(0, 0, S_F, 0, F_NONE, 0, "R3 no growth in free-run");
    tk(1, 0, S_F, 0, F_NONE, 0, "R6 requalify");
    tk(1, 0, S_F, 0, F_NONE, 0, "R6 requalify");
    tk(1, 0, S_L, 0, F_STEP, 0, "R8 step zero");
    for (int i = 0; i < 5; i++) tk(1, 0, S_L, 0, F_NONE, 0, "R2 lock time");
    tk(0, 0, S_H, 0, F_NONE, 0, "R2 holdover entry");

    // holdover grading
    for (int k = 1; k <= 103; k++) begin
      int te;
      logic [2:0] s;
      te = 50 * k;
      s  = (te > 5000) ? S_X : (te > 3500) ? S_D : S_H;
      if (k == 60)       tk(0, 0, s, te, F_NONE, 0, "R4 sixty tick outage passes");
      else if (k == 100) tk(0, 0, s, te, F_NONE, 0, "R4 equal to limit");
      else if (k == 101) tk(0, 0, s, te, F_NONE, 0, "R4 limit crossed");
      else if (k == 71)  tk(0, 0, s, te, F_NONE, 0, "R4 warning crossed");
      else               tk(0, 0, s, te, F_NONE, 0, "R3 accumulate");
    end

    // qualification restart, then reject
    tk(1, 2000, S_X, 5200, F_NONE, 0, "R6 qual");
    tk(1, 2000, S_X, 5250, F_NONE, 0, "R6 qual");
    tk(0, 2000, S_X, 5300, F_NONE, 0, "R6 drop restarts");
    tk(1, 2000, S_X, 5350, F_NONE, 0, "R6 qual");
    tk(1, 2000, S_X, 5400, F_NONE, 0, "R6 qual");
    tk(1, 2000, S_X, 5450, F_REJ, 0, "R7 reject");

    // slew from failed
    tk(1, 300, S_X, 5500, F_NONE, 0, "R7 requalify");
    tk(1, 300, S_X, 5550, F_NONE, 0, "R7 requalify");
    tk(1, 300, S_X, 5600, F_SLEW, -40, "R9 slew start");
    ph = 260;
    while (ph > 10) begin
      int a;
      a = (ph > 40) ? 40 : ph;
      tk(1, ph, S_X, 5600, F_SLEW, -a, "R9 slew step");
      ph -= a;
    end
    tk(1, ph, S_L, 0, F_NONE, 0, "R9 R10 lock after slew");

    // negative slew, aborted
    for (int i = 0; i < 5; i++) tk(1, 0, S_L, 0, F_NONE, 0, "R2 lock time");
    tk(0, 0, S_H, 0, F_NONE, 0, "R2 holdover entry");
    tk(0, 0, S_H, 50, F_NONE, 0, "R3 accumulate");
    tk(0, 0, S_H, 100, F_NONE, 0, "R3 accumulate");
    tk(1, -150, S_H, 150, F_NONE, 0, "R6 qual");
    tk(1, -150, S_H, 200, F_NONE, 0, "R6 qual");
    tk(1, -150, S_H, 250, F_SLEW, 40, "R9 negative slew");
    tk(0, -110, S_H, 250, F_NONE, 0, "R9 slew aborted");
    tk(0, -110, S_H, 300, F_NONE, 0, "R3 growth resumes");

    // saturation
    ffe_i = 16'd20000;
    tk(0, 0, S_X, 20300, F_NONE, 0, "R4 fail from holdover");
    tk(0, 0, S_X, 40300, F_NONE, 0, "R3 accumulate in failed");
    tk(0, 0, S_X, 60300, F_NONE, 0, "R3 accumulate in failed");
    tk(0, 0, S_X, 65535, F_NONE, 0, "R10 saturate");
    tk(0, 0, S_X, 65535, F_NONE, 0, "R10 stay saturated");
    ffe_i = 16'd50;
    tk(1, 0, S_X, 65535, F_NONE, 0, "R10 qual");
    tk(1, 0, S_X, 65535, F_NONE, 0, "R10 qual");
    tk(1, 0, S_L, 0, F_STEP, 0, "R10 cleared on lock");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule